// File: doc/BRIEF.md
# Pseudo-SRAM Control Bus Monitor

This block watches the control pins of a 16-bit pseudo-static RAM bus and samples them once per clock. From the sampled pins it works out the bus operation in progress. It also reports which of the two byte lanes the memory drives and which lanes it latches from the bus.

The monitor also follows the device power life cycle: the settling wait after power-up or deep standby, the dummy reads that have to come before normal use, and the active and standby states after that. Four sticky flags record rule violations:
- an access made before the device is ready,
- leaving deep standby, which destroys the stored contents,
- an access to one address held longer than the allowed cycle time,
- an address that moves while a write strobe is active.

The block is meant to sit next to a memory controller, either in a test harness or in silicon, as a protocol guard.

Top module: `psram_bus_monitor`

## Requirements
- R1: With chip select high, `mode_code` is 0 when the standby-select pin is high (retaining standby) and 1 when it is low (deep standby, contents lost). In both cases `lane_drive` and `lane_sample` are 0.
- R2: With chip select low, write enable high and output enable low, the byte selects pick the read code. Both selects low gives 3 with `lane_drive`=11. Only the lower select low gives 4 with `lane_drive`=01. Only the upper select low gives 5 with `lane_drive`=10. Bit 0 of a lane vector is data bits 0-7 and bit 1 is data bits 8-15.
- R3: With chip select and write enable low, the code is 6 for both selects low, 7 for lower only and 8 for upper only. `lane_sample` marks the selected lanes. With both selects high the code is 9 (abort) and no lane is sampled.
- R4: With chip select low and write enable high, the code is 2 with no lanes active in two cases: output enable high (any byte selects), or both byte selects high.
- R5: `mode_code` and the lane vectors reflect the pins sampled at the most recent rising clock edge. A pin change between edges does not show until the next edge.
- R6: After reset `pwr_state` is 0 (settling wait). It moves to 1 (dummy-read phase) once WAIT_CYC consecutive samples show chip select high and standby-select high.
- R7: In state 1, a dummy read is counted when chip select returns high after a low frame in which write enable stayed high. A frame with write enable low is not counted. After the third counted frame the state becomes 3 (retaining standby).
- R8: Once initialised, the state is 2 (active) while chip select is low. With chip select high it is 3 when standby-select is high and 4 (deep standby) when it is low. Leaving state 4 returns the state to 0 and sets the sticky `err_data_lost`.
- R9: A read or write (codes 3-8) sampled in state 0 or 4, or a write (codes 6-8) sampled in state 1, sets the sticky `err_early_access`. Dummy frames with output enable high do not set it.
- R10: More than LIMIT_CYC consecutive chip-select-low samples at one address set the sticky `err_cycle_overrun`. Exactly LIMIT_CYC samples do not set it. An address change or a chip-select edge restarts the count.
- R11: An address change between two consecutive samples that both show chip select and write enable low sets the sticky `err_addr_move`. An address change with write enable high does not set it.
- R12: Reset returns `pwr_state` to 0, `mode_code` to 0 and clears all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| stby_mode | input | 1 | Standby select, low requests deep standby |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| lb_n | input | 1 | Lower byte select, active low |
| ub_n | input | 1 | Upper byte select, active low |
| addr | input | ADDR_W | Memory address |
| mode_code | output | 4 | Decoded bus operation |
| lane_drive | output | 2 | Lanes the memory drives (reads) |
| lane_sample | output | 2 | Lanes the memory latches (writes) |
| pwr_state | output | 3 | Device power/initialisation state |
| err_early_access | output | 1 | Sticky: access before device ready |
| err_data_lost | output | 1 | Sticky: deep standby was left |
| err_cycle_overrun | output | 1 | Sticky: same-address cycle too long |
| err_addr_move | output | 1 | Sticky: address changed under write strobe |

## Verification
The decoder is driven with random pin combinations biased toward chip select low. This covers every pairing of write enable, output enable and byte selects, and separates write priority over output enable, the two disabled-output forms and the abort case. A directed pin change between edges separates a registered decode from a combinational one.

The power sequence is driven through an uncounted write-enable frame, then two and three good dummy frames, then the deep-standby round trip. This tells a frame counter apart from a plain edge counter. Cycle-length runs of exactly the limit and one past it, plus a split run with an address change, pin down the off-by-one and the restart rules. Address moves under write enable high and low isolate the write-strobe rule.

// File: rtl/psram_mon_pkg.sv
package psram_mon_pkg;

  typedef enum logic [3:0] {
    MD_STBY1    = 4'd0,
    MD_STBY2    = 4'd1,
    MD_OUT_DIS  = 4'd2,
    MD_RD_WORD  = 4'd3,
    MD_RD_LO    = 4'd4,
    MD_RD_HI    = 4'd5,
    MD_WR_WORD  = 4'd6,
    MD_WR_LO    = 4'd7,
    MD_WR_HI    = 4'd8,
    MD_WR_ABORT = 4'd9
  } bus_mode_t;

  typedef enum logic [2:0] {
    PW_WAIT   = 3'd0,
    PW_INIT   = 3'd1,
    PW_ACTIVE = 3'd2,
    PW_STBY1  = 3'd3,
    PW_STBY2  = 3'd4
  } pwr_state_t;

  typedef struct packed {
    logic cs_n;
    logic stby_mode;
    logic oe_n;
    logic we_n;
    logic lb_n;
    logic ub_n;
  } pin_set_t;

  localparam pin_set_t PINS_IDLE = '1;

  function automatic bus_mode_t classify(input pin_set_t p);
    bus_mode_t m;
    if (p.cs_n) begin
      m = p.stby_mode ? MD_STBY1 : MD_STBY2;
    end else if (!p.we_n) begin
      case ({p.ub_n, p.lb_n})
        2'b00:   m = MD_WR_WORD;
        2'b10:   m = MD_WR_LO;
        2'b01:   m = MD_WR_HI;
        default: m = MD_WR_ABORT;
      endcase
    end else if (p.oe_n) begin
      m = MD_OUT_DIS;
    end else begin
      case ({p.ub_n, p.lb_n})
        2'b00:   m = MD_RD_WORD;
        2'b10:   m = MD_RD_LO;
        2'b01:   m = MD_RD_HI;
        default: m = MD_OUT_DIS;
      endcase
    end
    return m;
  endfunction

  function automatic logic [1:0] drive_lanes(input bus_mode_t m);
    case (m)
      MD_RD_WORD: return 2'b11;
      MD_RD_LO:   return 2'b01;
      MD_RD_HI:   return 2'b10;
      default:    return 2'b00;
    endcase
  endfunction

  function automatic logic [1:0] sample_lanes(input bus_mode_t m);
    case (m)
      MD_WR_WORD: return 2'b11;
      MD_WR_LO:   return 2'b01;
      MD_WR_HI:   return 2'b10;
      default:    return 2'b00;
    endcase
  endfunction

  function automatic logic is_read(input bus_mode_t m);
    return (m == MD_RD_WORD) || (m == MD_RD_LO) || (m == MD_RD_HI);
  endfunction

  function automatic logic is_write(input bus_mode_t m);
    return (m == MD_WR_WORD) || (m == MD_WR_LO) || (m == MD_WR_HI);
  endfunction

endpackage

// File: rtl/psram_pin_sampler.sv
module psram_pin_sampler
  import psram_mon_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pin_set_t          pins_in,
  input  logic [ADDR_W-1:0] addr_in,
  output pin_set_t          cur,
  output pin_set_t          prv,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] prv_addr
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur      <= PINS_IDLE;
      prv      <= PINS_IDLE;
      cur_addr <= '0;
      prv_addr <= '0;
    end else begin
      cur      <= pins_in;
      prv      <= cur;
      cur_addr <= addr_in;
      prv_addr <= cur_addr;
    end
  end

endmodule

// File: rtl/psram_mode_decode.sv
module psram_mode_decode
  import psram_mon_pkg::*;
(
  input  pin_set_t  cur,
  output bus_mode_t mode,
  output logic [1:0] drive,
  output logic [1:0] sample
);

  always_comb begin
    mode   = classify(cur);
    drive  = drive_lanes(mode);
    sample = sample_lanes(mode);
  end

endmodule

// File: rtl/psram_power_fsm.sv
module psram_power_fsm
  import psram_mon_pkg::*;
#(
  parameter int WAIT_CYC   = 10000,
  parameter int INIT_READS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  pin_set_t   cur,
  input  pin_set_t   prv,
  input  bus_mode_t  mode,
  output pwr_state_t state,
  output logic       err_early,
  output logic       err_lost
);

  localparam int WAIT_W = $clog2(WAIT_CYC + 1);
  localparam int RD_W   = $clog2(INIT_READS + 1);

  pwr_state_t        nxt;
  logic [WAIT_W-1:0] wait_cnt;
  logic [RD_W-1:0]   rd_cnt;
  logic              frame_ok;
  logic              cs_fall, cs_rise, read_done, early_hit, settle_ok, lost_hit;

  assign cs_fall   = prv.cs_n & ~cur.cs_n;
  assign cs_rise   = ~prv.cs_n & cur.cs_n;
  assign read_done = cs_rise & frame_ok;
  assign settle_ok = cur.cs_n & cur.stby_mode;
  assign early_hit = (((state == PW_WAIT) || (state == PW_STBY2)) && (is_read(mode) || is_write(mode)))
                   || ((state == PW_INIT) && is_write(mode));
  assign lost_hit  = (state == PW_STBY2) && (nxt == PW_WAIT);

  always_comb begin
    nxt = state;
    case (state)
      PW_WAIT: begin
        if (cur.cs_n && !cur.stby_mode) nxt = PW_STBY2;
        else if (settle_ok && wait_cnt == WAIT_W'(WAIT_CYC - 1)) nxt = PW_INIT;
      end
      PW_INIT: begin
        if (cur.cs_n && !cur.stby_mode) nxt = PW_STBY2;
        else if (read_done && rd_cnt == RD_W'(INIT_READS - 1)) nxt = PW_STBY1;
      end
      PW_ACTIVE, PW_STBY1: begin
        if (!cur.cs_n)          nxt = PW_ACTIVE;
        else if (cur.stby_mode) nxt = PW_STBY1;
        else                    nxt = PW_STBY2;
      end
      PW_STBY2: begin
        if (settle_ok) nxt = PW_WAIT;
      end
      default: nxt = PW_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= PW_WAIT;
      wait_cnt  <= '0;
      rd_cnt    <= '0;
      frame_ok  <= 1'b0;
      err_early <= 1'b0;
      err_lost  <= 1'b0;
    end else begin
      state <= nxt;
      if (state == PW_WAIT && settle_ok && nxt == PW_WAIT) wait_cnt <= wait_cnt + 1'b1;
      else                                                 wait_cnt <= '0;
      if (state != PW_INIT)  rd_cnt <= '0;
      else if (read_done)    rd_cnt <= rd_cnt + 1'b1;
      if (cs_fall)                    frame_ok <= cur.we_n;
      else if (!cur.cs_n && !cur.we_n) frame_ok <= 1'b0;
      if (early_hit) err_early <= 1'b1;
      if (lost_hit)  err_lost  <= 1'b1;
    end
  end

  // R7
  active_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PW_ACTIVE) |-> ($past(state) == PW_ACTIVE || $past(state) == PW_STBY1));

  // R8
  lost_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_lost |=> err_lost);

  // R8
  stby2_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PW_WAIT && $past(state) == PW_STBY2) |-> err_lost);

  // R9
  early_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_early |=> err_early);

endmodule

// File: rtl/psram_cycle_guard.sv
module psram_cycle_guard
  import psram_mon_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int LIMIT_CYC = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pin_set_t          cur,
  input  pin_set_t          prv,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [ADDR_W-1:0] prv_addr,
  output logic              err_overrun,
  output logic              err_addr_move
);

  localparam int RUN_W = $clog2(LIMIT_CYC + 2);

  logic [RUN_W-1:0] run_cnt;
  logic addr_chg, restart, overrun_hit, move_hit;

  assign addr_chg    = (cur_addr != prv_addr);
  assign restart     = (prv.cs_n & ~cur.cs_n) | addr_chg;
  assign overrun_hit = ~cur.cs_n & ~restart & (run_cnt == RUN_W'(LIMIT_CYC));
  assign move_hit    = addr_chg & ~cur.cs_n & ~cur.we_n & ~prv.cs_n & ~prv.we_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt       <= '0;
      err_overrun   <= 1'b0;
      err_addr_move <= 1'b0;
    end else begin
      if (cur.cs_n)                           run_cnt <= '0;
      else if (restart)                       run_cnt <= RUN_W'(1);
      else if (run_cnt < RUN_W'(LIMIT_CYC))   run_cnt <= run_cnt + 1'b1;
      if (overrun_hit) err_overrun   <= 1'b1;
      if (move_hit)    err_addr_move <= 1'b1;
    end
  end

  // R10
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= RUN_W'(LIMIT_CYC));

  // R10
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> !$past(cur.cs_n));

  // R11
  addr_move_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_addr_move |=> err_addr_move);

endmodule

// File: rtl/psram_bus_monitor.sv
module psram_bus_monitor
  import psram_mon_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int WAIT_CYC   = 10000,
  parameter int INIT_READS = 3,
  parameter int LIMIT_CYC  = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              stby_mode,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              lb_n,
  input  logic              ub_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [3:0]        mode_code,
  output logic [1:0]        lane_drive,
  output logic [1:0]        lane_sample,
  output logic [2:0]        pwr_state,
  output logic              err_early_access,
  output logic              err_data_lost,
  output logic              err_cycle_overrun,
  output logic              err_addr_move
);

  pin_set_t          pins_w, cur_w, prv_w;
  logic [ADDR_W-1:0] cur_addr_w, prv_addr_w;
  bus_mode_t         mode_w;
  pwr_state_t        state_w;

  assign pins_w = '{cs_n: cs_n, stby_mode: stby_mode, oe_n: oe_n,
                    we_n: we_n, lb_n: lb_n, ub_n: ub_n};

  psram_pin_sampler #(.ADDR_W(ADDR_W)) sampler_i (
    .clk(clk), .rst_n(rst_n), .pins_in(pins_w), .addr_in(addr),
    .cur(cur_w), .prv(prv_w), .cur_addr(cur_addr_w), .prv_addr(prv_addr_w)
  );

  psram_mode_decode decode_i (
    .cur(cur_w), .mode(mode_w), .drive(lane_drive), .sample(lane_sample)
  );

  psram_power_fsm #(.WAIT_CYC(WAIT_CYC), .INIT_READS(INIT_READS)) power_i (
    .clk(clk), .rst_n(rst_n), .cur(cur_w), .prv(prv_w), .mode(mode_w),
    .state(state_w), .err_early(err_early_access), .err_lost(err_data_lost)
  );

  psram_cycle_guard #(.ADDR_W(ADDR_W), .LIMIT_CYC(LIMIT_CYC)) guard_i (
    .clk(clk), .rst_n(rst_n), .cur(cur_w), .prv(prv_w),
    .cur_addr(cur_addr_w), .prv_addr(prv_addr_w),
    .err_overrun(err_cycle_overrun), .err_addr_move(err_addr_move)
  );

  assign mode_code = mode_w;
  assign pwr_state = state_w;

  // R1
  standby_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_w.cs_n |-> (lane_drive == 2'b00 && lane_sample == 2'b00));

  // R2
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((|lane_drive) && (|lane_sample)));

  // R3
  write_needs_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_sample) |-> (!cur_w.we_n && !cur_w.cs_n));

endmodule

// File: tb/psram_bus_monitor_tb_top.sv
module psram_bus_monitor_tb_top;

  localparam int AW   = 20;
  localparam int WCYC = 20;
  localparam int LCYC = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, stby_mode = 1'b1, oe_n = 1'b1, we_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [3:0] mode_code;
  logic [1:0] lane_drive, lane_sample;
  logic [2:0] pwr_state;
  logic err_early_access, err_data_lost, err_cycle_overrun, err_addr_move;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  psram_bus_monitor #(.ADDR_W(AW), .WAIT_CYC(WCYC), .INIT_READS(3), .LIMIT_CYC(LCYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .stby_mode(stby_mode), .oe_n(oe_n),
    .we_n(we_n), .lb_n(lb_n), .ub_n(ub_n), .addr(addr),
    .mode_code(mode_code), .lane_drive(lane_drive), .lane_sample(lane_sample),
    .pwr_state(pwr_state), .err_early_access(err_early_access),
    .err_data_lost(err_data_lost), .err_cycle_overrun(err_cycle_overrun),
    .err_addr_move(err_addr_move)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // returns {code, drive, sample}
  function automatic logic [7:0] exp_decode(input logic c, input logic m, input logic o,
                                            input logic w, input logic l, input logic u);
    logic [3:0] code;
    logic [1:0] drv, smp;
    drv = 2'b00; smp = 2'b00;
    if (c) code = m ? 4'd0 : 4'd1;
    else if (!w) begin
      smp = {~u, ~l};
      if (!l && !u) code = 4'd6;
      else if (!l)  code = 4'd7;
      else if (!u)  code = 4'd8;
      else          code = 4'd9;
    end else if (!o && !(l && u)) begin
      drv = {~u, ~l};
      if (!l && !u) code = 4'd3;
      else if (!l)  code = 4'd4;
      else          code = 4'd5;
    end else code = 4'd2;
    return {code, drv, smp};
  endfunction

  task automatic step(input logic c, input logic m, input logic o, input logic w,
                      input logic l, input logic u, input logic [AW-1:0] a);
    @(negedge clk);
    cs_n = c; stby_mode = m; oe_n = o; we_n = w; lb_n = l; ub_n = u; addr = a;
    @(posedge clk);
    #5;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1, 1, 1, 1, 1, 1, addr);
  endtask

  task automatic frame(input logic w, input int len);
    for (int i = 0; i < len; i++) step(0, 1, 1, w, 1, 1, addr);
    idle(2);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cs_n = 1; stby_mode = 1; oe_n = 1; we_n = 1; lb_n = 1; ub_n = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic chk_flags(input string tag, input int e, input int l, input int o, input int m);
    chk({tag, " early"}, err_early_access, e);
    chk({tag, " lost"}, err_data_lost, l);
    chk({tag, " overrun"}, err_cycle_overrun, o);
    chk({tag, " addrmove"}, err_addr_move, m);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] ex;
    logic c, m, o, w, l, u;
    void'($urandom(32'd2718));
    do_reset();
    #5;
    // R12 reset state
    chk("R12 state", pwr_state, 0);
    chk("R12 mode", mode_code, 0);
    chk_flags("R12", 0, 0, 0, 0);

    // R1 R2 R3 R4 random decode
    for (int i = 0; i < 300; i++) begin
      c = ($urandom % 4) == 0;
      m = $urandom % 2; o = $urandom % 2; w = $urandom % 2;
      l = $urandom % 2; u = $urandom % 2;
      step(c, m, o, w, l, u, AW'($urandom));
      ex = exp_decode(c, m, o, w, l, u);
      if (c)                          begin chk("R1 code", mode_code, ex[7:4]); chk("R1 drv", lane_drive, ex[3:2]); chk("R1 smp", lane_sample, ex[1:0]); end
      else if (!w)                    begin chk("R3 code", mode_code, ex[7:4]); chk("R3 drv", lane_drive, ex[3:2]); chk("R3 smp", lane_sample, ex[1:0]); end
      else if (ex[7:4] == 4'd2)       begin chk("R4 code", mode_code, ex[7:4]); chk("R4 drv", lane_drive, ex[3:2]); chk("R4 smp", lane_sample, ex[1:0]); end
      else                            begin chk("R2 code", mode_code, ex[7:4]); chk("R2 drv", lane_drive, ex[3:2]); chk("R2 smp", lane_sample, ex[1:0]); end
    end

    // R1 deep standby directed, R3 abort directed
    step(1, 0, 0, 0, 0, 0, 0);
    chk("R1 deep", mode_code, 1);
    step(0, 1, 0, 0, 1, 1, 0);
    chk("R3 abort", mode_code, 9);
    chk("R3 abort smp", lane_sample, 0);

    // R5 registered decode
    step(0, 1, 0, 1, 0, 0, 0);
    @(negedge clk);
    we_n = 1'b0;
    #5;
    chk("R5 hold", mode_code, 3);
    @(posedge clk);
    #5;
    chk("R5 update", mode_code, 6);

    // power sequence
    do_reset();
    idle(10);
    chk("R6 still waiting", pwr_state, 0);
    idle(15);
    chk("R6 to init", pwr_state, 1);
    frame(1'b0, 2);
    frame(1'b1, 2);
    frame(1'b1, 2);
    chk("R7 two reads", pwr_state, 1);
    frame(1'b1, 2);
    idle(1);
    chk("R7 done", pwr_state, 3);
    chk("R9 dummy no flag", err_early_access, 0);
    for (int i = 0; i < 3; i++) step(0, 1, 1, 1, 1, 1, addr);
    chk("R8 active", pwr_state, 2);
    idle(2);
    chk("R8 stby1", pwr_state, 3);
    for (int i = 0; i < 3; i++) step(1, 0, 1, 1, 1, 1, addr);
    chk("R8 stby2", pwr_state, 4);
    chk("R8 not lost yet", err_data_lost, 0);
    idle(3);
    chk("R8 exit", pwr_state, 0);
    chk("R8 lost", err_data_lost, 1);
    step(0, 1, 0, 1, 0, 1, addr);
    step(0, 1, 0, 1, 0, 1, addr);
    idle(3);
    chk("R9 early", err_early_access, 1);

    // R10 cycle overrun
    do_reset();
    for (int i = 0; i < 30; i++) step(0, 1, 1, 1, 1, 1, 20'h00010);
    for (int i = 0; i < 30; i++) step(0, 1, 1, 1, 1, 1, 20'h00020);
    idle(3);
    chk("R10 restart", err_cycle_overrun, 0);
    for (int i = 0; i < LCYC; i++) step(0, 1, 1, 1, 1, 1, 20'h00020);
    idle(3);
    chk("R10 exact limit", err_cycle_overrun, 0);
    for (int i = 0; i < LCYC + 1; i++) step(0, 1, 1, 1, 1, 1, 20'h00020);
    idle(3);
    chk("R10 over", err_cycle_overrun, 1);

    // R11 address move
    do_reset();
    step(0, 1, 1, 1, 1, 1, 20'h00100);
    step(0, 1, 1, 1, 1, 1, 20'h00100);
    step(0, 1, 1, 1, 1, 1, 20'h00200);
    idle(3);
    chk("R11 read move ok", err_addr_move, 0);
    step(0, 1, 1, 0, 0, 1, 20'h00100);
    step(0, 1, 1, 0, 0, 1, 20'h00100);
    step(0, 1, 1, 0, 0, 1, 20'h00200);
    idle(3);
    chk("R11 write move", err_addr_move, 1);

    // R12 reset clears
    do_reset();
    #5;
    chk_flags("R12 clear", 0, 0, 0, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule